// File: doc/BRIEF.md
# Programmable Memory Wait-State Controller

This block sets the number of wait cycles for each access on an external memory bus. A 16-bit timing word, written by the CPU through a one-register port with byte enables, holds one timing code for a save-memory region and one for each of three ROM windows. The ROM windows are mirrors of the same memory and differ only in the timing fields they use.

The bus side raises `acc_start_i` for one cycle and gives a region number and a sequential flag with it. The block looks up the wait count, holds `acc_busy_o` high for the wait count plus one cycle, and pulses `acc_ready_o` in the last of those cycles. The code-to-cycle mapping is not linear. The sequential option also differs per window, so the lookup is specific to each region rather than a plain N-cycle counter.

Top module: `wait_state_ctrl`

## Requirements
- R1: After reset every writable bit of the timing word reads 0, and `cpu_rdata_o` bit 15 equals `cart_type_i`. A non-sequential region-0 access then takes 5 cycles and a sequential one takes 3.
- R2: `cpu_be_i[0]` enables writes to bits 7:0 and `cpu_be_i[1]` enables writes to bits 15:8. A byte whose enable is low keeps its value.
- R3: Bit 15 always reads `cart_type_i` and bit 13 always reads 0. Writes to either bit are ignored, so writing 0xFFFF reads back 0x5FFF with bit 15 taken from the pin.
- R4: A non-sequential access to ROM region 0, 1 or 2 uses the 2-bit code in bits 3:2, 6:5 or 9:8 respectively. The codes 0, 1, 2 and 3 give 4, 3, 2 and 8 wait cycles.
- R5: A sequential access to ROM region 0, 1 or 2 uses bit 4, 7 or 10 respectively. A value of 1 gives 1 wait cycle. A value of 0 gives 2 waits for region 0, 4 for region 1 and 8 for region 2.
- R6: Region 3 (save memory) uses the code in bits 1:0 with the 4/3/2/8 mapping. The sequential flag has no effect on region 3.
- R7: An access accepted at a clock edge keeps `acc_busy_o` high for W+1 cycles, where W is its wait count. `acc_ready_o` is high in the (W+1)th cycle after that edge.
- R8: `acc_ready_o` is high for exactly one cycle per access.
- R9: A start that arrives while an access is busy is held. It is accepted at the edge that ends the current access, so its ready pulse follows W+1 cycles later.
- R10: An access keeps the wait count taken when it was accepted. A write to the timing word during the access affects only later accesses.
- R11: Bits 12:11 drive `clk_sel_o` and bit 14 drives `prefetch_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | Write strobe for the timing word |
| cpu_be_i | input | 2 | Byte enables (bit 0 = low byte) |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read-back of the timing word |
| cart_type_i | input | 1 | Cartridge-type pin, shown on bit 15 |
| acc_start_i | input | 1 | Access start strobe |
| acc_region_i | input | 2 | Region: 0-2 ROM windows, 3 save memory |
| acc_seq_i | input | 1 | Sequential access flag |
| acc_busy_o | output | 1 | Access in progress |
| acc_ready_o | output | 1 | One-cycle completion pulse |
| clk_sel_o | output | 2 | Clock-output select field |
| prefetch_en_o | output | 1 | Prefetch-enable field |

## Verification
The assertions check, on every cycle, that the ready pulse lasts one cycle and that the counter counts down by one. They also check that a newly accepted access loads the count produced by the lookup, that a start arriving while busy is held, that disabled bytes keep their value and that the lookup only produces legal wait counts. The cycle length of each field code, region and sequential combination can only be shown by the bench's scenarios, which count cycles at the ports. The same holds for back-to-back queuing, for a write during an access leaving that access unchanged, and for the read-only bits.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int unsigned CFG_W  = 16;
  localparam int unsigned WAIT_W = 4;
  localparam int unsigned REG_W  = 2;

  localparam logic [CFG_W-1:0] WR_MASK = 16'h5FFF;
  localparam int unsigned BIT_CART = 15;
  localparam int unsigned BIT_PREF = 14;
  localparam int unsigned LSB_CSEL = 11;

  typedef enum logic [REG_W-1:0] {
    RG_ROM0 = 2'd0,
    RG_ROM1 = 2'd1,
    RG_ROM2 = 2'd2,
    RG_SAVE = 2'd3
  } region_e;

  function automatic logic [WAIT_W-1:0] first_waits(input logic [1:0] code);
    unique case (code)
      2'd0: first_waits = WAIT_W'(4);
      2'd1: first_waits = WAIT_W'(3);
      2'd2: first_waits = WAIT_W'(2);
      default: first_waits = WAIT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/wsc_cfg_reg.sv
module wsc_cfg_reg
  import wsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       be_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             cart_type_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  localparam int unsigned NBYTES = CFG_W / 8;

  logic [CFG_W-1:0] cfg_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[b*8 +: 8] <= '0;
      else if (wr_i && be_i[b]) cfg_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & WR_MASK[b*8 +: 8];
    end
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o = cfg_q;
    rdata_o[BIT_CART] = cart_type_i;
  end

  assert_low_byte_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !be_i[0]) |=> $stable(cfg_q[7:0]));
  assert_high_byte_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !be_i[1]) |=> $stable(cfg_q[15:8]));
endmodule

// File: rtl/wsc_timing_lut.sv
module wsc_timing_lut
  import wsc_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [REG_W-1:0]  region_i,
  input  logic              seq_i,
  output logic [WAIT_W-1:0] wait_o
);
  logic [WAIT_W-1:0] seq_slow;

  always_comb begin
    unique case (region_e'(region_i))
      RG_ROM0: seq_slow = WAIT_W'(2);
      RG_ROM1: seq_slow = WAIT_W'(4);
      default: seq_slow = WAIT_W'(8);
    endcase
  end

  always_comb begin
    unique case (region_e'(region_i))
      RG_ROM0: wait_o = seq_i ? (cfg_i[4]  ? WAIT_W'(1) : seq_slow) : first_waits(cfg_i[3:2]);
      RG_ROM1: wait_o = seq_i ? (cfg_i[7]  ? WAIT_W'(1) : seq_slow) : first_waits(cfg_i[6:5]);
      RG_ROM2: wait_o = seq_i ? (cfg_i[10] ? WAIT_W'(1) : seq_slow) : first_waits(cfg_i[9:8]);
      default: wait_o = first_waits(cfg_i[1:0]);  // save memory: never sequential
    endcase
  end

  always_comb begin
    assert_legal_wait_R4: assert (wait_o inside {WAIT_W'(1), WAIT_W'(2), WAIT_W'(3), WAIT_W'(4), WAIT_W'(8)});
  end
endmodule

// File: rtl/wsc_access_fsm.sv
module wsc_access_fsm
  import wsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  region_i,
  input  logic              seq_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [REG_W-1:0]  sel_region_o,
  output logic              sel_seq_o,
  output logic              busy_o,
  output logic              ready_o
);
  logic              busy_q, pend_q, pend_seq_q;
  logic [REG_W-1:0]  pend_region_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              done;

  assign done         = busy_q && (cnt_q == '0);
  assign sel_region_o = pend_q ? pend_region_q : region_i;
  assign sel_seq_o    = pend_q ? pend_seq_q    : seq_i;
  assign busy_o       = busy_q;
  assign ready_o      = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q        <= 1'b0;
      cnt_q         <= '0;
      pend_q        <= 1'b0;
      pend_seq_q    <= 1'b0;
      pend_region_q <= '0;
    end else if (!busy_q || done) begin
      if (pend_q || start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= wait_i;
        // a fresh start during the ending cycle waits behind the held one
        pend_q <= pend_q && start_i;
        if (pend_q && start_i) begin
          pend_region_q <= region_i;
          pend_seq_q    <= seq_i;
        end
      end else begin
        busy_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (start_i) begin
        pend_q        <= 1'b1;
        pend_region_q <= region_i;
        pend_seq_q    <= seq_i;
      end
    end
  end

  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_load_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (busy_q && cnt_q == $past(wait_i)));
  assert_hold_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done && start_i) |=> pend_q);
  assert_count_down_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl
  import wsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_wr_i,
  input  logic [1:0]  cpu_be_i,
  input  logic [15:0] cpu_wdata_i,
  output logic [15:0] cpu_rdata_o,
  input  logic        cart_type_i,
  input  logic        acc_start_i,
  input  logic [1:0]  acc_region_i,
  input  logic        acc_seq_i,
  output logic        acc_busy_o,
  output logic        acc_ready_o,
  output logic [1:0]  clk_sel_o,
  output logic        prefetch_en_o
);
  logic [CFG_W-1:0]  cfg;
  logic [REG_W-1:0]  sel_region;
  logic              sel_seq;
  logic [WAIT_W-1:0] wait_cnt;

  wsc_cfg_reg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (cpu_wr_i),
    .be_i        (cpu_be_i),
    .wdata_i     (cpu_wdata_i),
    .cart_type_i (cart_type_i),
    .cfg_o       (cfg),
    .rdata_o     (cpu_rdata_o)
  );

  wsc_timing_lut u_lut (
    .cfg_i    (cfg),
    .region_i (sel_region),
    .seq_i    (sel_seq),
    .wait_o   (wait_cnt)
  );

  wsc_access_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (acc_start_i),
    .region_i     (acc_region_i),
    .seq_i        (acc_seq_i),
    .wait_i       (wait_cnt),
    .sel_region_o (sel_region),
    .sel_seq_o    (sel_seq),
    .busy_o       (acc_busy_o),
    .ready_o      (acc_ready_o)
  );

  assign clk_sel_o     = cfg[LSB_CSEL +: 2];
  assign prefetch_en_o = cfg[BIT_PREF];
endmodule

// File: tb/wait_state_ctrl_tb.sv
module wait_state_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_be = 2'b00;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cart = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  region = '0;
  logic        seq = 1'b0;
  logic        busy, ready;
  logic [1:0]  clk_sel;
  logic        pref;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wait_state_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(cpu_wr), .cpu_be_i(cpu_be),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cart_type_i(cart),
    .acc_start_i(start), .acc_region_i(region), .acc_seq_i(seq),
    .acc_busy_o(busy), .acc_ready_o(ready), .clk_sel_o(clk_sel), .prefetch_en_o(pref)
  );

  // {cfg[15:0], region[1:0], seq, cycles[4:0]}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 2'd0, 1'b0, 5'd5},  // R1
    {16'h0000, 2'd0, 1'b1, 5'd3},  // R1 R5
    {16'h0000, 2'd1, 1'b1, 5'd5},  // R5
    {16'h0000, 2'd2, 1'b1, 5'd9},  // R5
    {16'h0004, 2'd0, 1'b0, 5'd4},  // R4
    {16'h0008, 2'd0, 1'b0, 5'd3},  // R4
    {16'h000C, 2'd0, 1'b0, 5'd9},  // R4
    {16'h0010, 2'd0, 1'b1, 5'd2},  // R5
    {16'h0080, 2'd1, 1'b1, 5'd2},  // R5
    {16'h0400, 2'd2, 1'b1, 5'd2},  // R5
    {16'h0020, 2'd1, 1'b0, 5'd4},  // R4
    {16'h0300, 2'd2, 1'b0, 5'd9},  // R4
    {16'h0003, 2'd3, 1'b0, 5'd9},  // R6
    {16'h0002, 2'd3, 1'b1, 5'd3},  // R6 seq ignored
    {16'h0010, 2'd1, 1'b1, 5'd5},  // R5 bit4 not used by region 1
    {16'h0048, 2'd1, 1'b0, 5'd3}   // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_be = be; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_be = 2'b00;
  endtask

  // returns cycle index of ready after the accepting edge, 0 if none within 20
  task automatic run_acc(input logic [1:0] rg, input logic sq, output int cyc);
    @(negedge clk);
    start = 1'b1; region = rg; seq = sq;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int n = 1; n <= 20; n++) begin
      if (ready && cyc == 0) cyc = n;
      if (cyc != 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    cart = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset readback", cpu_rdata, 16'h8000);
    check("R1 idle busy", busy, 0);
    check("R11 reset clk_sel", clk_sel, 0);
    cart = 1'b0;
    @(negedge clk);
    check("R3 cart pin low", cpu_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr_cfg(VEC[i][23:8], 2'b11);
      run_acc(VEC[i][7:6], VEC[i][5], c);
      check($sformatf("R4/R5/R6/R7 vec%0d", i), c, int'(VEC[i][4:0]));
    end

    // R3 read-only and unused bits
    wr_cfg(16'hFFFF, 2'b11);
    check("R3 write all ones", cpu_rdata, 16'h5FFF);
    cart = 1'b1;
    @(negedge clk);
    check("R3 cart pin high", cpu_rdata, 16'hDFFF);
    cart = 1'b0;

    // R2 byte enables
    wr_cfg(16'h0000, 2'b11);
    wr_cfg(16'hABCD, 2'b01);
    check("R2 low byte only", cpu_rdata, 16'h00CD);
    wr_cfg(16'h1200, 2'b10);
    check("R2 high byte only", cpu_rdata, 16'h12CD);
    check("R11 clk_sel", clk_sel, 2);
    check("R11 prefetch off", pref, 0);
    wr_cfg(16'h4000, 2'b11);
    check("R11 prefetch on", pref, 1);

    // R10 write during access
    wr_cfg(16'h0000, 2'b11);
    @(negedge clk);
    start = 1'b1; region = 2'd0; seq = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cpu_wr = 1'b1; cpu_be = 2'b11; cpu_wdata = 16'h0008;
    c = 0;
    for (int n = 1; n <= 20; n++) begin
      if (n == 2) cpu_wr = 1'b0;
      if (ready && c == 0) c = n;
      if (c != 0) break;
      @(negedge clk);
    end
    check("R10 in-flight access unchanged", c, 5);
    @(negedge clk);
    run_acc(2'd0, 1'b0, c);
    check("R10 later access uses new value", c, 3);

    // R9/R8 back-to-back: 5-cycle access, second (seq, 3 cycles) arrives while busy
    wr_cfg(16'h0000, 2'b11);
    @(negedge clk);
    start = 1'b1; region = 2'd0; seq = 1'b0;
    @(negedge clk);
    start = 1'b0;
    begin
      int first_r, second_r, n_ready;
      first_r = 0; second_r = 0; n_ready = 0;
      for (int n = 1; n <= 12; n++) begin
        if (n == 2) begin start = 1'b1; seq = 1'b1; end
        if (n == 3) start = 1'b0;
        if (ready) begin
          n_ready++;
          if (first_r == 0) first_r = n; else if (second_r == 0) second_r = n;
        end
        if (n == 6) check("R8 ready drops after one cycle", ready, 0);
        @(negedge clk);
      end
      check("R9 first ready", first_r, 5);
      check("R9 held access ready", second_r, 8);
      check("R8 one pulse per access", n_ready, 2);
      check("R9 idle afterwards", busy, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule